// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

A single-clock synchronous SRAM for use as a fast local store inside a larger chip. Every input (address, write data, strobes, chip enables and write controls) is captured on the rising clock edge. Writes are committed by the block itself, with no external write pulse. Read data returns through an output register, together with a valid flag.

An access sequence starts when either of two address strobes is low. One is the processor strobe and the other is the controller strobe. The strobe loads a fresh external address. After that, a 2-bit burst counter produces the following addresses. The counter steps only while the advance input is low. A mode input, sampled together with the strobe, picks linear or interleaved order for the two low address bits. If no strobe and no advance is present, the current address is held and the access repeats.

Writes can cover any subset of the four byte lanes. A lane is selected by its own lane-write input, which counts only while the lane gate is low. A separate global write covers all four lanes. A cycle started by the processor strobe is always a read. Three chip enables, of mixed polarity, must all be active for a strobe to open a new access.

Top module: `psb_sram`

## Requirements
- R1: After the synchronous active-low reset, `rvalid` is 0 and the block is deselected. No read result appears, even with the advance input active, until a strobe is accepted.
- R2: A read is a selected cycle with no lane written. Its data appears on `rdata`, with `rvalid` high, after the second rising edge following the edge that captured its inputs.
- R3: A strobe (`go_cpu_n` or `go_ctl_n` low) opens an access at `addr` only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A strobe with any enable inactive deselects the block: it gives no reads and no writes until the next accepted strobe.
- R4: With `ilv_mode`=0 at the strobe, each cycle with `step_n` low adds 1 modulo 4 to the burst count. The two low address bits are then (start + count) mod 4, so a fifth address wraps to the start. The upper address bits never change within a burst.
- R5: With `ilv_mode`=1 at the strobe, the two low address bits are start XOR count. Changes on `ilv_mode` without a strobe have no effect on the running burst.
- R6: With both strobes high and `step_n` high, the last address is reused and the access repeats.
- R7: Lane i covers `wdata` bits [8i+7:8i]. Lane i is written when `lane_gate_n`=0 and `lane_wr_n[i]`=0. With `lane_gate_n`=1, `lane_wr_n` has no effect.
- R8: `wr_all_n`=0 writes all four lanes, whatever `lane_gate_n` and `lane_wr_n` are.
- R9: A cycle that accepts `go_cpu_n` low is a read, and its write controls are ignored. When both strobes are low together, the processor strobe wins and the cycle is a read.
- R10: A read of the address written in the cycle just before it returns the new bytes in the written lanes and the old bytes in the other lanes.
- R11: A cycle that writes any lane gives no `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | External word address |
| go_cpu_n | input | 1 | Processor address strobe, active low (read cycle) |
| go_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| lane_gate_n | input | 1 | Gate for the lane write selects, active low |
| wr_all_n | input | 1 | Write all four lanes, active low |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
Inputs presented before rising edge N are captured at N. A read result from them is visible after edge N+2, and a write from them is visible to a read whose inputs are captured at N+1. The bench drives on the falling edge and pushes one expected entry per cycle into a queue that starts with two placeholder entries. At each falling edge it pops the entry from two cycles earlier, so every comparison lands exactly on the cycle its result is due. Writes update the behavioural memory in program order, which also covers the back-to-back bypass case. A missing, early or late `rvalid` therefore shows up as a mismatch in the cycle it occurs.

// File: rtl/psb_pkg.sv
// Package: shared constants, registered-control record and burst order function.
// Assumes a 32-bit word split into four 8-bit lanes and a 2-bit burst counter.
package psb_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BCNT_W = 2;

    // Control inputs after registration, all converted to active high.
    typedef struct packed {
        logic             stb_cpu;
        logic             stb_ctl;
        logic             adv;
        logic             ilv;
        logic             en_ok;
        logic             wr_all;
        logic             gate;
        logic [LANES-1:0] lane_wr;
    } ctl_t;

    // Low address bits for a given start value, burst count and order.
    function automatic logic [BCNT_W-1:0] burst_low(
        input logic [BCNT_W-1:0] start,
        input logic [BCNT_W-1:0] cnt,
        input logic              ilv
    );
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction
endpackage

// File: rtl/psb_inreg.sv
// Input register stage: captures address, write data and all controls on
// the rising edge, turning active-low pins into active-high fields.
// Assumes the chip enables are only meaningful together (folded to en_ok).
module psb_inreg
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              go_cpu_n,
    input  logic              go_ctl_n,
    input  logic              step_n,
    input  logic              ilv_mode,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              lane_gate_n,
    input  logic              wr_all_n,
    input  logic [WORD_W-1:0] wdata,
    output ctl_t              ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q
);
    ctl_t ctl_d;

    // Normalise pin polarities before registration.
    always_comb begin
        ctl_d.stb_cpu = ~go_cpu_n;
        ctl_d.stb_ctl = ~go_ctl_n;
        ctl_d.adv     = ~step_n;
        ctl_d.ilv     = ilv_mode;
        ctl_d.en_ok   = ~en_a_n & en_b & ~en_c_n;
        ctl_d.wr_all  = ~wr_all_n;
        ctl_d.gate    = ~lane_gate_n;
        ctl_d.lane_wr = ~lane_wr_n;
    end

    // Control register; cleared to "no strobe, no write" by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Address and data register; needs no reset as controls qualify it.
    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
    end
endmodule

// File: rtl/psb_burst.sv
// Burst sequencer and write decode: tracks selection, burst base, count and
// order, and forms the access (address, select, lane mask) for the cycle.
// Assumes registered controls from psb_inreg; a processor-strobe cycle reads.
module psb_burst
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              acc_sel,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_wmask
);
    localparam int UP_W = ADDR_W - BCNT_W;

    logic              sel_q, sel_n;
    logic [ADDR_W-1:0] base_q, base_n;
    logic [BCNT_W-1:0] cnt_q, cnt_n;
    logic              ilv_q, ilv_n;
    logic              start, take, cpu_cycle;
    logic [LANES-1:0]  lane_mask;

    // Next burst state from strobe, enables and advance.
    always_comb begin
        start     = ctl_q.stb_cpu | ctl_q.stb_ctl;
        take      = start & ctl_q.en_ok;
        cpu_cycle = take & ctl_q.stb_cpu;
        sel_n     = start ? ctl_q.en_ok : sel_q;
        base_n    = take ? addr_q : base_q;
        ilv_n     = take ? ctl_q.ilv : ilv_q;
        if (start)          cnt_n = '0;
        else if (ctl_q.adv) cnt_n = cnt_q + 1'b1;
        else                cnt_n = cnt_q;
    end

    // Burst state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            sel_q  <= sel_n;
            base_q <= base_n;
            cnt_q  <= cnt_n;
            ilv_q  <= ilv_n;
        end
    end

    // Per-lane write select: global write or gated lane select.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb lane_mask[g] = ctl_q.wr_all | (ctl_q.gate & ctl_q.lane_wr[g]);
    end

    // Access formed for this cycle.
    always_comb begin
        acc_sel   = sel_n;
        acc_addr  = {base_n[ADDR_W-1:BCNT_W],
                     burst_low(base_n[BCNT_W-1:0], cnt_n, ilv_n)};
        acc_wmask = (sel_n && !cpu_cycle) ? lane_mask : '0;
    end

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.stb_cpu || ctl_q.stb_ctl || ctl_q.adv) |=> $stable(cnt_q)); // R6
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.stb_cpu || ctl_q.stb_ctl) |=> $stable(base_q[ADDR_W-1:BCNT_W])); // R4
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.stb_ctl && !ctl_q.stb_cpu && !ctl_q.en_ok) |-> (!acc_sel && acc_wmask == '0)); // R3

    logic unused_up;
    always_comb unused_up = (UP_W < 0);
endmodule

// File: rtl/psb_array.sv
// Storage and read path: a byte-lane array with a one-entry pending write
// (committed a cycle later), per-lane bypass from that entry, and a two-stage
// registered read path. Assumes one access per cycle, read or write.
module psb_array
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_sel,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_wmask,
    input  logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              pw_v;
    logic [ADDR_W-1:0] pw_addr;
    logic [LANES-1:0]  pw_mask;
    logic [WORD_W-1:0] pw_data;
    logic [WORD_W-1:0] rd_raw, rd_q;
    logic              rd_req, rv_q;
    logic              pw_hit;

    always_comb rd_req = acc_sel && (acc_wmask == '0);
    always_comb pw_hit = pw_v && (pw_addr == acc_addr);

    // Pending write entry: holds this cycle's write until the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pw_v <= 1'b0;
        else        pw_v <= acc_sel && (acc_wmask != '0);
        pw_addr <= acc_addr;
        pw_mask <= acc_wmask;
        pw_data <= wdata_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Commit of the pending write for this lane.
        always_ff @(posedge clk) begin
            if (pw_v && pw_mask[g]) lane_mem[pw_addr] <= pw_data[g*LANE_W +: LANE_W];
        end

        // Lane read with bypass from the not yet committed write.
        always_comb rd_raw[g*LANE_W +: LANE_W] = (pw_hit && pw_mask[g])
            ? pw_data[g*LANE_W +: LANE_W] : lane_mem[acc_addr];
    end

    // Read stage and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q   <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            rv_q   <= rd_req;
            rvalid <= rv_q;
        end
        rd_q  <= rd_raw;
        rdata <= rd_q;
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(acc_sel && acc_wmask == '0, 2)); // R2
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wmask != '0) |=> !rv_q); // R11
    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wmask != '0) |-> acc_sel); // R3
endmodule

// File: rtl/psb_sram.sv
// Top: pipelined burst SRAM. Inputs are registered, the burst sequencer forms
// one access per cycle and the array returns reads two edges after capture.
module psb_sram
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              go_cpu_n,
    input  logic              go_ctl_n,
    input  logic              step_n,
    input  logic              ilv_mode,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              lane_gate_n,
    input  logic              wr_all_n,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    ctl_t              ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              acc_sel;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_wmask;

    psb_inreg #(.ADDR_W(ADDR_W)) u_inreg (
        .clk(clk), .rst_n(rst_n), .addr(addr), .go_cpu_n(go_cpu_n),
        .go_ctl_n(go_ctl_n), .step_n(step_n), .ilv_mode(ilv_mode),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .lane_wr_n(lane_wr_n),
        .lane_gate_n(lane_gate_n), .wr_all_n(wr_all_n), .wdata(wdata),
        .ctl_q(ctl_q), .addr_q(addr_q), .wdata_q(wdata_q)
    );

    psb_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .addr_q(addr_q),
        .acc_sel(acc_sel), .acc_addr(acc_addr), .acc_wmask(acc_wmask)
    );

    psb_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_addr(acc_addr),
        .acc_wmask(acc_wmask), .wdata_q(wdata_q), .rdata(rdata), .rvalid(rvalid)
    );

    AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.stb_cpu && acc_sel) |-> (acc_wmask == '0)); // R9
endmodule

// File: tb/psb_sram_test.sv
module psb_sram_test;
    localparam int PERIOD = 10;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic go_cpu_n, go_ctl_n, step_n, ilv_mode, en_a_n, en_b, en_c_n;
    logic [3:0] lane_wr_n;
    logic lane_gate_n, wr_all_n;
    logic [31:0] wdata, rdata;
    logic rvalid;

    always #(PERIOD/2) clk = ~clk;

    psb_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .go_cpu_n(go_cpu_n),
        .go_ctl_n(go_ctl_n), .step_n(step_n), .ilv_mode(ilv_mode),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .lane_wr_n(lane_wr_n),
        .lane_gate_n(lane_gate_n), .wr_all_n(wr_all_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct {
        bit          skip;
        bit          v;
        logic [31:0] d;
        string       req;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [31:0] mmem [int];
    bit m_sel = 0;
    int m_base = 0, m_cnt = 0;
    bit m_ilv = 0;

    function automatic logic [31:0] pat(int a);
        return {8'(a) ^ 8'h5A, 8'(a) + 8'h11, ~8'(a), 8'(a)};
    endfunction

    function automatic int low_of(int b, int c, bit il);
        return il ? ((b ^ c) & 3) : ((b + c) & 3);
    endfunction

    // Model the cycle whose inputs are now on the pins and queue its result.
    task automatic model_push(string req);
        exp_t e;
        bit cpu;
        int a;
        logic [3:0] m;
        e.skip = 0; e.v = 0; e.d = '0; e.req = req;
        cpu = 0;
        if (!rst_n) begin
            m_sel = 0; m_base = 0; m_cnt = 0; m_ilv = 0;
        end else begin
            if (!go_cpu_n || !go_ctl_n) begin
                m_cnt = 0;
                if (!en_a_n && en_b && !en_c_n) begin
                    m_sel = 1; m_base = int'(addr); m_ilv = ilv_mode; cpu = !go_cpu_n;
                end else m_sel = 0;
            end else if (!step_n) m_cnt = (m_cnt + 1) & 3;
            if (m_sel) begin
                a = (m_base & ~3) | low_of(m_base & 3, m_cnt, m_ilv);
                if (cpu) m = 4'h0;
                else if (!wr_all_n) m = 4'hF;
                else if (!lane_gate_n) m = ~lane_wr_n;
                else m = 4'h0;
                if (m != 0) begin
                    for (int i = 0; i < 4; i++)
                        if (m[i]) mmem[a][i*8 +: 8] = wdata[i*8 +: 8];
                end else begin
                    e.v = 1;
                    e.d = mmem.exists(a) ? mmem[a] : 32'h0;
                end
            end
        end
        q.push_back(e);
    endtask

    task automatic check_front();
        exp_t e;
        e = q.pop_front();
        if (e.skip) return;
        vectors++;
        if (rvalid !== e.v) begin
            errors++;
            $display("FAIL %s: rvalid %b expected %b at %0t", e.req, rvalid, e.v, $time);
        end else if (e.v && rdata !== e.d) begin
            errors++;
            $display("FAIL %s: rdata %h expected %h at %0t", e.req, rdata, e.d, $time);
        end
    endtask

    // Apply current pin values for one cycle and check the due output.
    task automatic apply(string req);
        model_push(req);
        @(posedge clk);
        @(negedge clk);
        check_front();
    endtask

    task automatic idle();
        go_cpu_n = 1; go_ctl_n = 1; step_n = 1;
        lane_gate_n = 1; wr_all_n = 1; lane_wr_n = 4'hF;
    endtask

    task automatic strobe(bit cpu, int a, bit il);
        idle();
        if (cpu) go_cpu_n = 0; else go_ctl_n = 0;
        addr = AW'(a); ilv_mode = il;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            finish_run();
        end
    end

    initial begin
        exp_t s;
        s.skip = 1; s.v = 0; s.d = '0; s.req = "";
        q.push_back(s); q.push_back(s);
        rst_n = 0; addr = '0; ilv_mode = 0; wdata = '0;
        en_a_n = 0; en_b = 1; en_c_n = 0;
        idle();
        @(negedge clk);
        for (int i = 0; i < 4; i++) apply("R1 reset");
        rst_n = 1;
        for (int i = 0; i < 2; i++) apply("R1 idle after reset");
        step_n = 0;
        for (int i = 0; i < 2; i++) apply("R1 advance while deselected");

        // Fill 0..31 with global writes (R8), one controller strobe each
        for (int a = 0; a < 32; a++) begin
            strobe(0, a, 0); wr_all_n = 0; wdata = pat(a);
            apply("R8 global write fill");
        end
        // Single reads, latency (R2)
        for (int a = 3; a < 32; a += 7) begin
            strobe(1, a, 0); apply("R2 single read");
        end
        idle(); apply("R2 drain"); apply("R2 drain");

        // Linear burst from 6 with a hold in the middle and wrap (R4, R6)
        strobe(0, 6, 0); apply("R4 linear start");
        idle(); step_n = 0; apply("R4 linear step");
        idle(); apply("R6 hold repeat");
        step_n = 0; apply("R4 linear step");
        apply("R4 linear step");
        apply("R4 linear wrap");

        // Interleaved burst from 5; mode pin toggled mid-burst (R5)
        strobe(1, 5, 1); apply("R5 interleave start");
        idle(); step_n = 0; ilv_mode = 0; apply("R5 interleave step");
        apply("R5 interleave step");
        ilv_mode = 1; apply("R5 interleave step");
        idle(); apply("R5 drain"); apply("R5 drain");

        // Gated lane write then immediate read (R7, R10)
        strobe(0, 10, 0); lane_gate_n = 0; lane_wr_n = 4'b1010; wdata = 32'hAABBCCDD;
        apply("R7 lanes 0 and 2 write");
        idle(); apply("R10 bypass read after lane write");
        lane_gate_n = 1; lane_wr_n = 4'h0; wdata = 32'h01020304;
        apply("R7 ungated selects ignored");
        wr_all_n = 0; lane_gate_n = 1; lane_wr_n = 4'hF; wdata = 32'h11223344;
        apply("R8 global write overrides");
        idle(); apply("R10 bypass read after global write");
        lane_gate_n = 0; lane_wr_n = 4'b0111; wdata = 32'hEE000000;
        apply("R11 lane write, no valid");
        idle(); apply("R10 bypass lane 3");

        // Processor strobe ignores writes; both strobes low (R9)
        strobe(1, 12, 0); wr_all_n = 0; wdata = 32'hDEADBEEF;
        apply("R9 processor cycle reads");
        strobe(1, 13, 0); go_ctl_n = 0; wr_all_n = 0; wdata = 32'hCAFEF00D;
        apply("R9 both strobes read");
        idle(); wr_all_n = 0; wdata = 32'h0BADC0DE;
        apply("R9 hold after processor strobe writes");
        idle(); apply("R9 readback");
        strobe(1, 12, 0); apply("R9 address 12 unchanged");
        idle(); apply("R9 drain"); apply("R9 drain");

        // Deselect through each enable (R3)
        for (int k = 0; k < 3; k++) begin
            strobe(0, 20 + k, 0); wr_all_n = 0; wdata = 32'h55555555;
            if (k == 0) en_a_n = 1; else if (k == 1) en_b = 0; else en_c_n = 1;
            apply("R3 strobe with enable off");
            en_a_n = 0; en_b = 1; en_c_n = 0;
            idle(); wr_all_n = 0; apply("R3 deselected write dropped");
            idle(); step_n = 0; apply("R3 deselected no read");
            strobe(1, 20 + k, 0); apply("R3 memory unchanged");
        end

        // Burst write, linear from 17, then read back interleaved (R4, R7, R5)
        strobe(0, 17, 0); wr_all_n = 0; wdata = 32'hA0000000; apply("R4 burst write");
        for (int i = 1; i < 4; i++) begin
            idle(); step_n = 0; lane_gate_n = 0; lane_wr_n = 4'b1110;
            wdata = 32'h000000B0 + i; apply("R7 burst lane write");
        end
        strobe(1, 17, 1); apply("R5 interleave readback");
        for (int i = 1; i < 4; i++) begin
            idle(); step_n = 0; apply("R5 interleave readback");
        end
        idle(); go_cpu_n = 1;
        strobe(0, 40, 0); go_ctl_n = 1; go_cpu_n = 1; en_b = 0; go_ctl_n = 0;
        apply("R3 final deselect");
        en_b = 1; idle(); apply("R2 drain"); apply("R2 drain"); apply("R2 drain");

        done = 1;
        finish_run();
    end
endmodule